// File: doc/BRIEF.md
# Subcarrier power difference accumulator

This block sits behind an FFT in an OFDM receiver. It takes the FFT output as a stream of complex bins, N per symbol, each with a bin index and a valid strobe. For every bin it forms the power I² + Q². It then squares the difference between that power and the power of a partner bin, and adds the result into a cost accumulator. A blind frequency-offset estimator evaluates this cost at several trial offsets and picks the offset with the smallest cost.

Two partner choices are supported on one datapath and are picked per run. In frequency mode the partner is the neighbouring bin of the same symbol. In time mode the partner is the same bin of the previous symbol, which is held in an N-entry power memory. A start command latches the mode and the symbol count L. After the L-th symbol the cost is presented with a one-cycle done pulse and is then held.

Top module: `pwr_diff_acc`

## Requirements
- R1: The power of a bin is re_i² + im_i², with both components 12-bit two's complement. The largest power is 2^23, for -2048 on both components.
- R2: With mode 0 (frequency), each symbol adds the sum over k = 0..N-2 of (P[k+1] - P[k])². The last bin of a symbol has no partner. A pair never spans two symbols.
- R3: With mode 1 (time), symbol s ≥ 1 adds the sum over all k of (P_s[k] - P_{s-1}[k])². The first symbol of a run only loads the power memory and adds nothing.
- R4: A start_i pulse while the block is idle begins a run. It clears the cost and samples mode_i and num_sym_i, where num_sym_i is L, from 1 to 256. L counts every symbol, including the loading symbol in time mode. Bins arrive in the order 0..N-1, and a symbol ends on the valid sample whose bin index is N-1.
- R5: While a run is in progress, changes on mode_i and num_sym_i have no effect, and start_i is ignored.
- R6: Cycles with valid_i low contribute nothing. Valid samples presented while idle are ignored: no done pulse, and cost_o is unchanged.
- R7: done_o is high for exactly one cycle, starting with the third rising edge counted from the edge that samples the last bin of the run. cost_o takes the new cost at that same edge and holds it until the next done.
- R8: The cost never wraps. Alternating extreme powers (2^23 and 0) over L = 256 symbols in frequency mode give exactly 16128·2^46.
- R9: After reset, done_o is 0 and cost_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run; accepted only when idle |
| mode_i | input | 1 | 0 = frequency partner, 1 = time partner |
| num_sym_i | input | 9 | Symbols per run, L, 1..256 |
| valid_i | input | 1 | Bin sample valid |
| bin_i | input | 6 | Bin index, 0..N-1 |
| re_i | input | 12 | Real component, signed |
| im_i | input | 12 | Imaginary component, signed |
| cost_o | output | 62 | Accumulated cost, held between runs |
| done_o | output | 1 | One-cycle pulse when the cost is ready |

## Verification
The main function is driven with four kinds of input. A constant value must give zero in both modes. A ramp across bins that repeats every symbol must be nonzero in frequency mode and zero in time mode. A ramp across symbols that is flat over the bins must give the reverse. A pseudo-random pattern, once with idle cycles between samples, checks the exact sums. Directed runs cover the following:
- L = 1 in both modes.
- Mode and start disturbed in the middle of a run.
- Samples presented while idle.
- The extreme-value case over 256 symbols.
- The exact cycle on which done_o rises and then falls.

// File: rtl/pda_pkg.sv
package pda_pkg;
  typedef enum logic {
    MODE_FREQ = 1'b0,
    MODE_TIME = 1'b1
  } pda_mode_e;
endpackage

// File: rtl/pda_ctrl.sv
module pda_ctrl
  import pda_pkg::*;
#(
  parameter int N_BINS = 64,
  parameter int SYM_W  = 9,
  localparam int BIN_W = $clog2(N_BINS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [SYM_W-1:0] num_sym_i,
  input  logic             valid_i,
  input  logic [BIN_W-1:0] bin_i,
  input  logic             pipe_busy_i,
  output logic             accept_o,
  output logic             first_o,
  output logic             last_o,
  output logic             clear_o,
  output pda_mode_e        mode_o
);
  logic             run_q;
  logic [SYM_W-1:0] nsym_q, cnt_q;
  pda_mode_e        mode_q;
  logic             eos;

  assign clear_o  = start_i && !run_q && !pipe_busy_i;
  assign accept_o = valid_i && run_q;
  assign eos      = accept_o && (bin_i == BIN_W'(N_BINS - 1));
  assign last_o   = eos && (cnt_q == nsym_q - SYM_W'(1));
  assign first_o  = (cnt_q == '0);
  assign mode_o   = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      nsym_q <= SYM_W'(1);
      cnt_q  <= '0;
      mode_q <= MODE_FREQ;
    end else if (clear_o) begin
      run_q  <= 1'b1;
      nsym_q <= num_sym_i;
      cnt_q  <= '0;
      mode_q <= pda_mode_e'(mode_i);
    end else if (eos) begin
      cnt_q <= cnt_q + SYM_W'(1);
      if (last_o) run_q <= 1'b0;
    end
  end

  // R5
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && $past(run_q) |-> $stable(mode_q) && $stable(nsym_q));

  // R4
  sym_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> cnt_q < nsym_q);
endmodule

// File: rtl/pda_power.sv
module pda_power #(
  parameter int N_BINS = 64,
  parameter int IQ_W   = 12,
  localparam int BIN_W = $clog2(N_BINS),
  localparam int PW    = 2 * IQ_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   accept_i,
  input  logic [BIN_W-1:0]       bin_i,
  input  logic signed [IQ_W-1:0] re_i,
  input  logic signed [IQ_W-1:0] im_i,
  input  logic                   first_i,
  input  logic                   last_i,
  output logic                   v_o,
  output logic [PW-1:0]          pwr_o,
  output logic [BIN_W-1:0]       bin_o,
  output logic                   fill_o,
  output logic                   last_o
);
  logic signed [PW-1:0] re_sq, im_sq;
  logic [PW-1:0]        pwr_d;

  assign re_sq = re_i * re_i;
  assign im_sq = im_i * im_i;
  // each square is at most 2^22, so the sum fits unsigned PW bits
  assign pwr_d = $unsigned(re_sq) + $unsigned(im_sq);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o    <= 1'b0;
      pwr_o  <= '0;
      bin_o  <= '0;
      fill_o <= 1'b0;
      last_o <= 1'b0;
    end else begin
      v_o    <= accept_i;
      last_o <= accept_i && last_i;
      if (accept_i) begin
        pwr_o  <= pwr_d;
        bin_o  <= bin_i;
        fill_o <= first_i;
      end
    end
  end

  // R1
  pwr_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_o |-> pwr_o <= (PW'(1) << (PW - 1)));
endmodule

// File: rtl/pda_pair.sv
module pda_pair
  import pda_pkg::*;
#(
  parameter int N_BINS = 64,
  parameter int IQ_W   = 12,
  localparam int BIN_W = $clog2(N_BINS),
  localparam int PW    = 2 * IQ_W,
  localparam int SQ_W  = 2 * PW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pda_mode_e        mode_i,
  input  logic             v_i,
  input  logic [PW-1:0]    pwr_i,
  input  logic [BIN_W-1:0] bin_i,
  input  logic             fill_i,
  input  logic             last_i,
  output logic             v_o,
  output logic             pv_o,
  output logic [SQ_W-1:0]  sq_o,
  output logic             last_o
);
  logic [PW-1:0]      mem_q [N_BINS];
  logic [PW-1:0]      prev_q, partner;
  logic               has_pair;
  logic signed [PW:0] diff;
  logic [PW:0]        mag;

  assign partner  = (mode_i == MODE_TIME) ? mem_q[bin_i] : prev_q;
  assign has_pair = (mode_i == MODE_TIME) ? !fill_i : (bin_i != '0);
  assign diff     = $signed({1'b0, pwr_i}) - $signed({1'b0, partner});
  assign mag      = diff[PW] ? $unsigned(-diff) : $unsigned(diff);

  always_ff @(posedge clk_i) begin
    if (v_i) mem_q[bin_i] <= pwr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      v_o    <= 1'b0;
      pv_o   <= 1'b0;
      sq_o   <= '0;
      last_o <= 1'b0;
    end else begin
      v_o    <= v_i;
      pv_o   <= v_i && has_pair;
      last_o <= v_i && last_i;
      if (v_i) prev_q <= pwr_i;
      // |diff| <= 2^(PW-1), so the low PW bits hold the magnitude
      if (v_i && has_pair) sq_o <= mag[PW-1:0] * mag[PW-1:0];
    end
  end
endmodule

// File: rtl/pwr_diff_acc.sv
module pwr_diff_acc
  import pda_pkg::*;
#(
  parameter int N_BINS = 64,
  parameter int IQ_W   = 12,
  parameter int L_MAX  = 256,
  localparam int BIN_W = $clog2(N_BINS),
  localparam int SYM_W = $clog2(L_MAX + 1),
  localparam int PW    = 2 * IQ_W,
  localparam int SQ_W  = 2 * PW,
  localparam int ACC_W = SQ_W + $clog2(N_BINS) + $clog2(L_MAX)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   mode_i,
  input  logic [SYM_W-1:0]       num_sym_i,
  input  logic                   valid_i,
  input  logic [BIN_W-1:0]       bin_i,
  input  logic signed [IQ_W-1:0] re_i,
  input  logic signed [IQ_W-1:0] im_i,
  output logic [ACC_W-1:0]       cost_o,
  output logic                   done_o
);
  logic             accept, first, last_in, clear;
  pda_mode_e        mode;
  logic             v1, fill1, last1;
  logic [PW-1:0]    pwr1;
  logic [BIN_W-1:0] bin1;
  logic             v2, pv2, last2;
  logic [SQ_W-1:0]  sq2;
  logic [ACC_W-1:0] acc_q, acc_d;

  pda_ctrl #(.N_BINS(N_BINS), .SYM_W(SYM_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .mode_i, .num_sym_i, .valid_i, .bin_i,
    .pipe_busy_i(v1 | v2), .accept_o(accept), .first_o(first),
    .last_o(last_in), .clear_o(clear), .mode_o(mode)
  );

  pda_power #(.N_BINS(N_BINS), .IQ_W(IQ_W)) u_pwr (
    .clk_i, .rst_ni, .accept_i(accept), .bin_i, .re_i, .im_i,
    .first_i(first), .last_i(last_in), .v_o(v1), .pwr_o(pwr1),
    .bin_o(bin1), .fill_o(fill1), .last_o(last1)
  );

  pda_pair #(.N_BINS(N_BINS), .IQ_W(IQ_W)) u_pair (
    .clk_i, .rst_ni, .mode_i(mode), .v_i(v1), .pwr_i(pwr1), .bin_i(bin1),
    .fill_i(fill1), .last_i(last1), .v_o(v2), .pv_o(pv2), .sq_o(sq2),
    .last_o(last2)
  );

  assign acc_d = acc_q + (pv2 ? ACC_W'(sq2) : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      cost_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= last2;
      if (clear) acc_q <= '0;
      else       acc_q <= acc_d;
      if (last2) cost_o <= acc_d;
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  cost_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(cost_o));

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv2 |=> acc_q >= $past(acc_q));
endmodule

// File: tb/sim_pwr_diff_acc.sv
module sim_pwr_diff_acc;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, mode = 1'b0, valid = 1'b0;
  logic [8:0]  nsym = 9'd1;
  logic [5:0]  bin = '0;
  logic signed [11:0] re = '0, im = '0;
  logic [61:0] cost;
  logic        done;

  int errors = 0, checks = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  pwr_diff_acc u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .num_sym_i(nsym), .valid_i(valid), .bin_i(bin), .re_i(re), .im_i(im),
    .cost_o(cost), .done_o(done)
  );

  typedef struct packed {
    logic       m;
    logic [8:0] n;
    logic [2:0] p;
    logic       g;
  } vec_t;

  // mode, symbols, pattern, gaps
  localparam vec_t TBL [8] = '{
    '{1'b0, 9'd2, 3'd0, 1'b0},
    '{1'b1, 9'd3, 3'd0, 1'b0},
    '{1'b0, 9'd2, 3'd1, 1'b0},
    '{1'b1, 9'd2, 3'd1, 1'b0},
    '{1'b0, 9'd3, 3'd2, 1'b0},
    '{1'b1, 9'd3, 3'd2, 1'b0},
    '{1'b0, 9'd4, 3'd3, 1'b1},
    '{1'b1, 9'd4, 3'd3, 1'b0}
  };

  function automatic int gen_re(int p, int s, int k);
    case (p)
      0: return 300;
      1: return k * 20;
      2: return s * 50 - 100;
      3: return ((s * 1103 + k * 2749 + s * k * 71) % 4096) - 2048;
      default: return (k % 2 == 1) ? -2048 : 0;
    endcase
  endfunction

  function automatic int gen_im(int p, int s, int k);
    case (p)
      0: return -200;
      1: return -k * 5;
      2: return s * 7;
      3: return ((s * 577 + k * 3181 + s * k * 13) % 4096) - 2048;
      default: return (k % 2 == 1) ? -2048 : 0;
    endcase
  endfunction

  function automatic longint cost_model(int m, int ns, int p);
    longint prev [N];
    longint acc = 0;
    for (int s = 0; s < ns; s++) begin
      longint last = 0;
      for (int k = 0; k < N; k++) begin
        longint a = gen_re(p, s, k), b = gen_im(p, s, k);
        longint pw = a * a + b * b;
        longint d;
        if (m == 0 && k > 0) begin d = pw - last; acc += d * d; end
        if (m == 1 && s > 0) begin d = pw - prev[k]; acc += d * d; end
        prev[k] = pw;
        last = pw;
      end
    end
    return acc;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // disturb: in symbol 1 flip mode, pulse start and change the count
  task automatic run(int m, int ns, int p, bit g, bit disturb, string tag);
    longint exp = cost_model(m, ns, p);
    @(negedge clk);
    start = 1'b1; mode = m[0]; nsym = ns[8:0];
    @(negedge clk);
    start = 1'b0;
    for (int s = 0; s < ns; s++) begin
      for (int k = 0; k < N; k++) begin
        valid = 1'b1; bin = k[5:0];
        re = 12'(gen_re(p, s, k)); im = 12'(gen_im(p, s, k));
        if (disturb && s == 1 && k == 5) begin
          start = 1'b1; mode = ~m[0]; nsym = 9'd1;
        end else start = 1'b0;
        if (g && !(s == ns - 1 && k == N - 1)) begin
          @(negedge clk);
          valid = 1'b0; start = 1'b0; re = 12'sd999;
        end
        if (!(s == ns - 1 && k == N - 1)) @(negedge clk);
      end
    end
    @(negedge clk);
    valid = 1'b0; start = 1'b0;
    chk(done == 1'b0, {tag, " R7 early1"}, longint'(done), 0);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R7 early2"}, longint'(done), 0);
    @(negedge clk);
    chk(done == 1'b1, {tag, " R7 done"}, longint'(done), 1);
    chk({2'b0, cost} == 64'(exp), tag, longint'(cost), exp);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R7 pulse"}, longint'(done), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [61:0] held;
    bit seen;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(done == 1'b0, "R9 done", longint'(done), 0);
    chk(cost == '0, "R9 cost", longint'(cost), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 table of patterns
    for (int i = 0; i < 8; i++)
      run(int'(TBL[i].m), int'(TBL[i].n), int'(TBL[i].p), TBL[i].g, 1'b0,
          TBL[i].m ? "R3 R1 table" : "R2 R1 table");

    // R3 single symbol in time mode only loads the memory
    run(1, 1, 3, 1'b0, 1'b0, "R3 L1");
    chk(cost == '0, "R3 L1 zero", longint'(cost), 0);
    // R2 single symbol in frequency mode
    run(0, 1, 3, 1'b0, 1'b0, "R2 L1");

    // R5 mode, count and start disturbed mid-run
    run(0, 3, 3, 1'b0, 1'b1, "R5 freq");
    run(1, 3, 3, 1'b0, 1'b1, "R5 time");

    // R6 samples while idle are ignored
    held = cost; seen = 1'b0;
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      valid = 1'b1; bin = k[5:0]; re = 12'sd1000; im = -12'sd700;
      if (done) seen = 1'b1;
    end
    @(negedge clk); valid = 1'b0;
    repeat (4) begin @(negedge clk); if (done) seen = 1'b1; end
    chk(!seen, "R6 idle done", longint'(seen), 0);
    chk(cost == held, "R6 idle cost", longint'(cost), longint'(held));
    run(1, 2, 2, 1'b0, 1'b0, "R6 after idle");

    // R8 extreme powers over the full count
    run(0, 256, 4, 1'b0, 1'b0, "R8 model");
    chk({2'b0, cost} == (64'd16128 << 46), "R8 exact", longint'(cost),
        longint'(64'd16128 << 46));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule